// File: doc/BRIEF.md
# Multi-Polynomial PRBS and Ramp Test Pattern Generator

This block supplies test samples for a set of data converters. Each cycle it can produce one word that holds `NUM_CONV` converters, each with `SAMPLES` samples of `SAMPLE_BITS` bits. A 3-bit control word picks the pattern. The pattern is either one of four pseudo-random binary sequences or a counting ramp.

In PRBS mode a single linear feedback shift register walks forward by the full word width in one clock. The bits it makes fill the word starting from the most significant bit. In ramp mode one shared counter feeds every converter, and the samples inside a word count upward.

Output is a registered `out_valid`/`out_data` pair, and `enable` decides whether the pattern moves forward. When the control word changes, the pattern restarts from its defined seed.

Top module: `test_pattern_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_data` is 0. The internal mode after reset counts as control word 3'b000.
- R2: With `test_ctl[2]`=0, `test_ctl[1:0]` selects the polynomial: 00 is x^23+x^18+1, 01 is x^15+x^14+1, 10 is x^9+x^5+1, 11 is x^7+x^6+1.
- R3: For a polynomial x^P+x^T+1, each new bit is state[P-1] XOR state[T-1]. The register then shifts left by one, and the new bit enters at bit 0. Within one word, the k-th bit made (k=0 first) lands at `out_data[W-1-k]`, where W is the word width.
- R4: The register is seeded with P ones on reset and whenever `test_ctl` differs from the control word of the previous cycle. The ramp counter restarts at 0 under the same conditions.
- R5: With `test_ctl[2]`=1 (ramp mode), sample s of converter c sits at `out_data[(c*SAMPLES+s)*SAMPLE_BITS +: SAMPLE_BITS]`. Every converter carries the same values.
- R6: In ramp mode each sample is the previous one plus 1, modulo 2^SAMPLE_BITS. This holds within a word and across words, so the sample after all ones is 0.
- R7: `out_valid` in a cycle equals `enable` in the previous cycle. A word is emitted one cycle after `enable` is sampled high.
- R8: While `enable` is low, `out_data` holds its value and the pattern state does not advance. The sequence resumes where it stopped.
- R9: When a control change and `enable` are sampled at the same edge, the emitted word is the first word of the new mode, produced from the fresh seed.
- R10: The PRBS register is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Advance the pattern and emit a word |
| test_ctl | input | 3 | Bit 2 selects ramp; bits 1:0 select the polynomial |
| out_valid | output | 1 | A new word is present on `out_data` |
| out_data | output | NUM_CONV*SAMPLES*SAMPLE_BITS | Test sample word |

## Verification
The two functions that can meet in one cycle are the reseed on a control change and the advance under `enable`. The bench provokes this by changing `test_ctl` at the same edge that `enable` is high, both with `enable` already high and with `enable` rising from low. The reference model is judged by whether the first word after the change comes from the new seed and the new polynomial, rather than from the old state. The bench also changes the control word while `enable` is low. In that case the reseed must take effect with no word emitted, and the next word must still start from the seed.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   localparam int LFSR_MAX = 23;

   typedef enum logic [1:0] {
      POLY_23 = 2'b00,
      POLY_15 = 2'b01,
      POLY_9  = 2'b10,
      POLY_7  = 2'b11
   } poly_e;

   // degree of the selected polynomial
   function automatic int poly_len(input logic [1:0] sel);
      case (sel)
         POLY_23: return 23;
         POLY_15: return 15;
         POLY_9:  return 9;
         default: return 7;
      endcase
   endfunction

   // middle term of the selected polynomial
   function automatic int poly_tap(input logic [1:0] sel);
      case (sel)
         POLY_23: return 18;
         POLY_15: return 14;
         POLY_9:  return 5;
         default: return 6;
      endcase
   endfunction

   function automatic logic [LFSR_MAX-1:0] poly_seed(input logic [1:0] sel);
      logic [LFSR_MAX:0] t;
      t = (LFSR_MAX+1)'(1) << poly_len(sel);
      t = t - (LFSR_MAX+1)'(1);
      return t[LFSR_MAX-1:0];
   endfunction
endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reseed,
   input  logic             advance,
   input  logic [1:0]       poly_sel,
   output logic [WIDTH-1:0] pattern
);
   import tpg_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("tpg_prbs: WIDTH must be positive");
   end

   logic [LFSR_MAX-1:0] state_q, base, stepped;

   assign base = reseed ? poly_seed(poly_sel) : state_q;

   // unrolled walk of WIDTH single-bit steps
   always_comb begin
      logic [LFSR_MAX-1:0] s;
      logic [LFSR_MAX-1:0] mask;
      logic nb;
      int p;
      int t;
      p    = poly_len(poly_sel);
      t    = poly_tap(poly_sel);
      mask = poly_seed(poly_sel);
      s    = base;
      pattern = '0;
      for (int k = 0; k < WIDTH; k++) begin
         nb = s[p-1] ^ s[t-1];
         pattern[WIDTH-1-k] = nb;
         s = {s[LFSR_MAX-2:0], nb} & mask;
      end
      stepped = s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       state_q <= poly_seed(POLY_23);
      else if (advance) state_q <= stepped;
      else              state_q <= base;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         assert_lfsr_live_R10: assert (state_q != '0)
            else $error("PRBS register reached zero");
      end
   end
endmodule

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
   parameter int NUM_CONV    = 2,
   parameter int SAMPLES     = 2,
   parameter int SAMPLE_BITS = 8,
   localparam int WIDTH      = NUM_CONV * SAMPLES * SAMPLE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reseed,
   input  logic             advance,
   output logic [WIDTH-1:0] pattern
);
   if (NUM_CONV < 1 || SAMPLES < 1 || SAMPLE_BITS < 1) begin : g_bad_cfg
      $error("tpg_ramp: all dimensions must be positive");
   end

   logic [SAMPLE_BITS-1:0] base_q, base;

   assign base = reseed ? '0 : base_q;

   for (genvar c = 0; c < NUM_CONV; c++) begin : g_conv
      for (genvar s = 0; s < SAMPLES; s++) begin : g_smp
         assign pattern[(c*SAMPLES+s)*SAMPLE_BITS +: SAMPLE_BITS] =
            base + SAMPLE_BITS'(s);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       base_q <= '0;
      else if (advance) base_q <= base + SAMPLE_BITS'(SAMPLES);
      else              base_q <= base;
   end

   assert_ramp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !reseed) |=> (base_q == $past(base_q) + SAMPLE_BITS'(SAMPLES)))
      else $error("ramp counter skipped");
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
   parameter int NUM_CONV    = 2,
   parameter int SAMPLES     = 2,
   parameter int SAMPLE_BITS = 8,
   localparam int WIDTH      = NUM_CONV * SAMPLES * SAMPLE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [2:0]       test_ctl,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data
);
   logic [2:0]       ctl_q;
   logic             changed, ramp_mode;
   logic [WIDTH-1:0] prbs_pat, ramp_pat;

   assign changed   = (test_ctl != ctl_q);
   assign ramp_mode = test_ctl[2];

   tpg_prbs #(.WIDTH(WIDTH)) i_prbs (
      .clk     (clk),
      .rst_n   (rst_n),
      .reseed  (changed),
      .advance (enable && !ramp_mode),
      .poly_sel(test_ctl[1:0]),
      .pattern (prbs_pat)
   );

   tpg_ramp #(.NUM_CONV(NUM_CONV), .SAMPLES(SAMPLES), .SAMPLE_BITS(SAMPLE_BITS)) i_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .reseed  (changed),
      .advance (enable && ramp_mode),
      .pattern (ramp_pat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q     <= 3'b000;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         ctl_q     <= test_ctl;
         out_valid <= enable;
         if (enable) out_data <= ramp_mode ? ramp_pat : prbs_pat;
      end
   end

   assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> out_valid) else $error("valid missing");
   assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !out_valid) else $error("valid without enable");
   assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> $stable(out_data)) else $error("data moved while idle");
endmodule

// File: tb/test_test_pattern_gen.sv
module test_test_pattern_gen;
   localparam int NC = 2, NS = 2, NB = 8;
   localparam int W  = NC * NS * NB;

   logic         clk = 0;
   logic         rst_n = 0;
   logic         enable = 0;
   logic [2:0]   test_ctl = 3'b000;
   logic         out_valid;
   logic [W-1:0] out_data;

   always #5 clk = ~clk;

   test_pattern_gen #(.NUM_CONV(NC), .SAMPLES(NS), .SAMPLE_BITS(NB)) i_test_pattern_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .test_ctl(test_ctl),
      .out_valid(out_valid), .out_data(out_data)
   );

   int    checks = 0, fails = 0;
   string tag = "R1";
   bit    comparing = 0;

   // behavioural reference
   logic [2:0]   m_ctl;
   logic [22:0]  m_lfsr;
   int           m_ramp;
   logic         m_valid;
   logic [W-1:0] m_data;
   int           wrap_seen = 0;
   int           prev_last = -1;
   bit           nonzero_seen = 0;

   function automatic int deg(input logic [1:0] s);
      return (s == 2'b00) ? 23 : (s == 2'b01) ? 15 : (s == 2'b10) ? 9 : 7;
   endfunction
   function automatic int mid(input logic [1:0] s);
      return (s == 2'b00) ? 18 : (s == 2'b01) ? 14 : (s == 2'b10) ? 5 : 6;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = 3'b000; m_lfsr = 23'h7FFFFF; m_ramp = 0; m_valid = 0; m_data = '0;
      end else begin
         if (test_ctl != m_ctl) begin
            int p;
            m_ctl = test_ctl;
            p = deg(test_ctl[1:0]);
            m_lfsr = '0;
            for (int i = 0; i < p; i++) m_lfsr[i] = 1'b1;
            m_ramp = 0;
         end
         m_valid = enable;
         if (enable) begin
            if (test_ctl[2]) begin
               for (int c = 0; c < NC; c++)
                  for (int s = 0; s < NS; s++)
                     m_data[(c*NS+s)*NB +: NB] = NB'((m_ramp + s) % (1 << NB));
               m_ramp = (m_ramp + NS) % (1 << NB);
            end else begin
               int p, t;
               p = deg(test_ctl[1:0]);
               t = mid(test_ctl[1:0]);
               for (int k = 0; k < W; k++) begin
                  logic b;
                  b = m_lfsr[p-1] ^ m_lfsr[t-1];
                  m_data[W-1-k] = b;
                  m_lfsr = {m_lfsr[21:0], b};
                  m_lfsr[p] = 1'b0;
                  if (p < 22) m_lfsr[22] = 1'b0;
               end
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (comparing) begin
         check(out_valid == m_valid, tag, "valid", W'(out_valid), W'(m_valid));
         check(out_data == m_data, tag, "data", out_data, m_data);
         if (out_valid && m_ctl[2]) begin
            if (prev_last == 255 && out_data[NB-1:0] == 0) wrap_seen++;
            prev_last = int'(out_data[(NS-1)*NB +: NB]);
         end
         if (out_valid && !m_ctl[2] && out_data != '0) nonzero_seen = 1;
      end
   end

   task automatic step(input int n, input bit en, input logic [2:0] ctl);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         enable = en; test_ctl = ctl;
      end
   endtask

   int watchdog = 0;
   always @(posedge clk) begin
      watchdog++;
      if (watchdog > 20000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected<20000", watchdog);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 0 && out_data == '0, "R1", "in reset", out_data, '0);
      comparing = 1;
      tag = "R1"; rst_n = 1;
      step(2, 0, 3'b000);
      tag = "R2_R3";   step(30, 1, 3'b000);
      tag = "R9";      step(20, 1, 3'b001);
      tag = "R9";      step(15, 1, 3'b010);
      tag = "R8";      step(3, 0, 3'b010);
      tag = "R8";      step(4, 1, 3'b010);
      tag = "R7";      step(1, 0, 3'b010); step(1, 1, 3'b010); step(2, 0, 3'b010);
      tag = "R4";      step(3, 0, 3'b011);
      tag = "R4";      step(15, 1, 3'b011);
      tag = "R5_R6";   step(150, 1, 3'b100);
      tag = "R8";      step(5, 0, 3'b100); step(20, 1, 3'b100);
      tag = "R9";      step(3, 0, 3'b000); step(10, 1, 3'b111);
      tag = "R1";      rst_n = 0; step(2, 1, 3'b101);
      rst_n = 1;       step(1, 0, 3'b000);
      tag = "R10";     step(20, 1, 3'b010);
      @(negedge clk);
      comparing = 0;
      check(wrap_seen > 0, "R6", "ramp wrap observed", W'(wrap_seen), W'(1));
      check(nonzero_seen, "R10", "PRBS words nonzero", W'(nonzero_seen), W'(1));
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule